// File: doc/BRIEF.md
# Parallel One-Hot NFA Pattern Matcher

This block scans a stream of symbols, one per clock, against five fixed patterns at once. Each state of the nondeterministic automaton is one flip-flop, so any number of partial matches can be in progress together. A state turns on when one of its predecessor states was on and the symbol line for that transition is high.

The automaton's entry point counts as permanently active, so a pattern may begin at any position in the stream. A `+` term is a state that loops back to itself on its own character. A `.*` term is a state that loops back to itself on any symbol.

The symbols arrive already decoded as one-hot lines. Each accepting state drives one bit of the match vector. A synchronous init input discards all partial matches, for example between two independent streams.

Top module: `onehot_nfa_matcher`

## Requirements
- R1: After the synchronous reset, and after any clock edge with `init_i` high, every bit of `match_o` is 0 and every partial match is discarded. `init_i` takes priority over a symbol presented in the same cycle.
- R2: `match_o[0]` reports the pattern ab+cd: an a, one or more b, a c, then a d.
- R3: `match_o[1]` reports the pattern ab+ce.
- R4: `match_o[2]` reports ab+c.*f. The wildcard consumes any symbol cycle in which at least one line of `sym_i` is high. A cycle with all lines low breaks the wildcard run.
- R5: `match_o[3]` reports b[d-f]a: a b, then one of d, e or f, then an a.
- R6: `match_o[4]` reports the pattern bdc.
- R7: Matching is unanchored and the match bits are not latched. An occurrence may start at any symbol, and overlapping occurrences are each reported. Every occurrence pulses its bit for exactly one cycle.
- R8: A match bit is high in the cycle that follows the clock edge at which the pattern's last symbol was sampled. It is low in every cycle with no completed occurrence.
- R9: The lines of `sym_i` are coded as follows:
  - bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f, bit 6 = any other character.
  - At most one line may be high in a cycle.
  - An all-zero vector is a symbol that matches no character and no wildcard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Synchronous clear of all automaton states |
| sym_i | input | NSYM (7) | One-hot symbol lines, coded as in R9 |
| match_o | output | 5 | Per-pattern match pulses, bit k for pattern k+1 |

## Verification
The hardest situation to reach from the ports is a `.*` run that survives many cycles while b+ loops and other partial matches also pass through the same prefix states. A bug in the self-loops or in the shared prefix shows only in such streams. An exhaustive sweep of every four-symbol word, restarted with init each time, covers the short forms of all five patterns. A long pseudo-random stream, weighted towards a, b and c and with occasional all-zero cycles, builds the long and overlapping cases. A bench model that scans the symbol history predicts every output cycle.

// File: rtl/nfa_rules_pkg.sv
package nfa_rules_pkg;
  // symbol line positions
  localparam int SYM_A     = 0;
  localparam int SYM_B     = 1;
  localparam int SYM_C     = 2;
  localparam int SYM_D     = 3;
  localparam int SYM_E     = 4;
  localparam int SYM_F     = 5;
  localparam int SYM_OTHER = 6;
  localparam int NSYM_MIN  = 7;

  // decoded condition positions
  localparam int CL_A   = 0;
  localparam int CL_B   = 1;
  localparam int CL_C   = 2;
  localparam int CL_D   = 3;
  localparam int CL_E   = 4;
  localparam int CL_F   = 5;
  localparam int CL_DF  = 6;
  localparam int CL_ANY = 7;
  localparam int NCLS   = 8;

  // automaton state positions
  localparam int ST_A    = 0;   // saw a
  localparam int ST_BP   = 1;   // saw a b+
  localparam int ST_C    = 2;   // saw a b+ c
  localparam int ST_M1   = 3;   // accept pattern 1
  localparam int ST_M2   = 4;   // accept pattern 2
  localparam int ST_DOT  = 5;   // inside .*
  localparam int ST_M3   = 6;   // accept pattern 3
  localparam int ST_B    = 7;   // saw b (patterns 4, 5)
  localparam int ST_DF   = 8;   // saw b[d-f]
  localparam int ST_M4   = 9;   // accept pattern 4
  localparam int ST_BD   = 10;  // saw bd
  localparam int ST_M5   = 11;  // accept pattern 5
  localparam int NST     = 12;
  localparam int FANIN   = 2;
  localparam int NRULE   = 5;
endpackage

// File: rtl/nfa_sym_decode.sv
module nfa_sym_decode
  import nfa_rules_pkg::*;
#(
  parameter int NSYM = NSYM_MIN
) (
  input  logic [NSYM-1:0] sym_i,
  output logic [NCLS-1:0] cls_o
);
  localparam int NLETTER = SYM_F + 1;

  for (genvar g = 0; g < NLETTER; g++) begin : g_letter
    assign cls_o[g] = sym_i[g];
  end

  assign cls_o[CL_DF]  = sym_i[SYM_D] | sym_i[SYM_E] | sym_i[SYM_F];
  assign cls_o[CL_ANY] = |sym_i;
endmodule

// File: rtl/nfa_state_bit.sv
module nfa_state_bit #(
  parameter int NIN = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [NIN-1:0] pred,
  input  logic [NIN-1:0] cond,
  output logic           q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else            q <= |(pred & cond);
  end
endmodule

// File: rtl/onehot_nfa_matcher.sv
module onehot_nfa_matcher
  import nfa_rules_pkg::*;
#(
  parameter int NSYM = NSYM_MIN
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        init_i,
  input  logic [NSYM-1:0]             sym_i,
  output logic [nfa_rules_pkg::NRULE-1:0] match_o
);
  logic [NCLS-1:0]  cls;
  logic [NST-1:0]   st;
  logic [FANIN-1:0] pred_m [NST];
  logic [FANIN-1:0] cond_m [NST];
  logic             start;

  assign start = 1'b1;  // entry state is always armed

  nfa_sym_decode #(.NSYM(NSYM)) u_dec (
    .sym_i (sym_i),
    .cls_o (cls)
  );

  // transition table: pair k of each state is (predecessor, condition)
  always_comb begin
    for (int s = 0; s < NST; s++) begin
      pred_m[s] = '0;
      cond_m[s] = '0;
    end
    pred_m[ST_A]   = {1'b0, start};          cond_m[ST_A]   = {1'b0, cls[CL_A]};
    pred_m[ST_BP]  = {st[ST_BP], st[ST_A]};  cond_m[ST_BP]  = {cls[CL_B], cls[CL_B]};
    pred_m[ST_C]   = {1'b0, st[ST_BP]};      cond_m[ST_C]   = {1'b0, cls[CL_C]};
    pred_m[ST_M1]  = {1'b0, st[ST_C]};       cond_m[ST_M1]  = {1'b0, cls[CL_D]};
    pred_m[ST_M2]  = {1'b0, st[ST_C]};       cond_m[ST_M2]  = {1'b0, cls[CL_E]};
    pred_m[ST_DOT] = {st[ST_DOT], st[ST_C]}; cond_m[ST_DOT] = {cls[CL_ANY], cls[CL_ANY]};
    pred_m[ST_M3]  = {st[ST_DOT], st[ST_C]}; cond_m[ST_M3]  = {cls[CL_F], cls[CL_F]};
    pred_m[ST_B]   = {1'b0, start};          cond_m[ST_B]   = {1'b0, cls[CL_B]};
    pred_m[ST_DF]  = {1'b0, st[ST_B]};       cond_m[ST_DF]  = {1'b0, cls[CL_DF]};
    pred_m[ST_M4]  = {1'b0, st[ST_DF]};      cond_m[ST_M4]  = {1'b0, cls[CL_A]};
    pred_m[ST_BD]  = {1'b0, st[ST_B]};       cond_m[ST_BD]  = {1'b0, cls[CL_D]};
    pred_m[ST_M5]  = {1'b0, st[ST_BD]};      cond_m[ST_M5]  = {1'b0, cls[CL_C]};
  end

  for (genvar g = 0; g < NST; g++) begin : g_state
    nfa_state_bit #(.NIN(FANIN)) u_bit (
      .clk  (clk),
      .rst  (rst),
      .clr  (init_i),
      .pred (pred_m[g]),
      .cond (cond_m[g]),
      .q    (st[g])
    );
  end

  // accepting states are flops, so the outputs are registered
  assign match_o = {st[ST_M5], st[ST_M4], st[ST_M3], st[ST_M2], st[ST_M1]};
endmodule

// File: rtl/onehot_nfa_matcher_chk.sv
module onehot_nfa_matcher_chk
  import nfa_rules_pkg::*;
#(
  parameter int NSYM = NSYM_MIN
) (
  input logic            clk,
  input logic            rst,
  input logic            init_i,
  input logic [NSYM-1:0] sym_i,
  input logic [NRULE-1:0] match_o
);
  a_r1_init_clears: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (match_o == '0));
  a_r2_ends_on_d: assert property (@(posedge clk) disable iff (rst)
    match_o[0] |-> $past(sym_i[SYM_D]));
  a_r3_ends_on_e: assert property (@(posedge clk) disable iff (rst)
    match_o[1] |-> $past(sym_i[SYM_E]));
  a_r4_ends_on_f: assert property (@(posedge clk) disable iff (rst)
    match_o[2] |-> $past(sym_i[SYM_F]));
  a_r5_ends_on_a: assert property (@(posedge clk) disable iff (rst)
    match_o[3] |-> $past(sym_i[SYM_A]));
  a_r6_ends_on_c: assert property (@(posedge clk) disable iff (rst)
    match_o[4] |-> $past(sym_i[SYM_C]));
  a_r8_one_rule_per_symbol: assert property (@(posedge clk) disable iff (rst)
    $onehot0($past(sym_i)) |-> $onehot0(match_o));
endmodule

bind onehot_nfa_matcher onehot_nfa_matcher_chk #(.NSYM(NSYM)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .init_i  (init_i),
  .sym_i   (sym_i),
  .match_o (match_o)
);

// File: tb/onehot_nfa_matcher_test.sv
`timescale 1ns/1ps
module onehot_nfa_matcher_test;
  localparam int NSYM = 7;
  localparam int NR   = 5;
  localparam int NONE = 7;  // code for an all-zero symbol vector
  // codes 0..6 follow the R9 line order: a b c d e f other

  logic            clk = 1'b0;
  logic            rst;
  logic            init_i;
  logic [NSYM-1:0] sym_i;
  logic [NR-1:0]   match_o;

  int hist [256];
  int n = 0;
  int base = 0;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  onehot_nfa_matcher #(.NSYM(NSYM)) uut (
    .clk(clk), .rst(rst), .init_i(init_i), .sym_i(sym_i), .match_o(match_o)
  );

  function automatic int h(int i);
    return hist[i & 255];
  endfunction

  // a b+ c ending at position k
  function automatic bit abpc_end(int k);
    int j;
    if (k - 2 < base) return 1'b0;
    if (h(k) != 2 || h(k-1) != 1) return 1'b0;
    j = k - 1;
    while (j >= base && h(j) == 1) j--;
    return (j >= base && h(j) == 0);
  endfunction

  function automatic logic [NR-1:0] expect_at(int i);
    logic [NR-1:0] e;
    e = '0;
    // R2: ab+cd
    e[0] = (h(i) == 3) && (i - 1 >= base) && abpc_end(i - 1);
    // R3: ab+ce
    e[1] = (h(i) == 4) && (i - 1 >= base) && abpc_end(i - 1);
    // R4: ab+c.*f, a zero vector breaks the wildcard
    if (h(i) == 5) begin
      for (int k = i - 1; k >= base; k--) begin
        if (h(k) == NONE) break;
        if (abpc_end(k)) begin e[2] = 1'b1; break; end
      end
    end
    // R5: b[d-f]a
    e[3] = (i - 2 >= base) && h(i) == 0 && h(i-1) >= 3 && h(i-1) <= 5 && h(i-2) == 1;
    // R6: bdc
    e[4] = (i - 2 >= base) && h(i) == 2 && h(i-1) == 3 && h(i-2) == 1;
    return e;
  endfunction

  task automatic check(logic [NR-1:0] exp, string what);
    tests++;
    if (match_o !== exp) begin
      fails++;
      $display("FAIL %s: match_o got %b expected %b (symbol %0d)", what, match_o, exp, n);
    end
  endtask

  // R8: result sampled one edge after the symbol, away from the edge
  task automatic step(int code);
    sym_i = (code == NONE) ? '0 : (NSYM'(1) << code);
    hist[n & 255] = code;
    n++;
    @(posedge clk);
    @(negedge clk);
    check(expect_at(n - 1), "R2-6 per-pattern model, R7 R8 timing");
  endtask

  task automatic do_init();
    sym_i  = '0;
    init_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    init_i = 1'b0;
    base = n;
    check('0, "R1 init clears");
  endtask

  task automatic word(string s);
    for (int i = 0; i < s.len(); i++) begin
      case (s[i])
        "a": step(0); "b": step(1); "c": step(2); "d": step(3);
        "e": step(4); "f": step(5); "x": step(6); default: step(NONE);
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int cnt;
    rst = 1'b1; init_i = 1'b0; sym_i = '0;
    repeat (3) @(negedge clk);
    check('0, "R1 reset state");
    rst = 1'b0;
    @(negedge clk);
    check('0, "R1 after reset");

    // directed: explicit values
    do_init(); word("abbbc"); step(3);
    check(5'b00001, "R2 abbbcd");
    do_init(); word("xabc"); step(4);
    check(5'b00010, "R3 xabce");
    do_init(); word("abcxdaf");
    check(5'b00100, "R4 wildcard run");
    do_init(); word("abcd"); step(NONE); step(5);
    check(5'b00000, "R4 zero vector breaks wildcard");
    do_init(); word("bea");
    check(5'b01000, "R5 bea");
    do_init(); word("bbdc");
    check(5'b10000, "R6 bbdc");
    do_init(); word("abcff"); check(5'b00100, "R7 repeat pulse");
    step(6); check(5'b00000, "R7 not latched");
    word("bdabdc"); check(5'b10000, "R7 overlapping");

    // R1: init wins over a completing symbol in the same cycle
    do_init(); word("abc");
    sym_i = NSYM'(1) << 3; init_i = 1'b1;
    @(posedge clk); @(negedge clk);
    init_i = 1'b0; base = n;
    check('0, "R1 init priority");
    step(3);
    check('0, "R1 prefix discarded");

    // exhaustive sweep: every four-symbol word over the seven lines
    for (int w = 0; w < 2401; w++) begin
      int v;
      do_init();
      v = w;
      for (int p = 0; p < 4; p++) begin
        step(v % 7);
        v = v / 7;
      end
    end

    // long weighted pseudo-random stream with periodic init
    lfsr = 16'hACE1;
    cnt = 0;
    do_init();
    for (int t = 0; t < 20000; t++) begin
      int code;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[3:0])
        4'd0, 4'd1, 4'd2:         code = 0;
        4'd3, 4'd4, 4'd5, 4'd6:   code = 1;
        4'd7, 4'd8, 4'd9:         code = 2;
        4'd10, 4'd14:             code = 3;
        4'd11:                    code = 4;
        4'd12:                    code = 5;
        4'd13:                    code = 6;
        default:                  code = NONE;
      endcase
      step(code);
      cnt++;
      if (cnt == 64) begin cnt = 0; do_init(); end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule